// File: doc/BRIEF.md
# Interlace-Capable Standard-Definition Sync Generator

This block produces the horizontal and vertical timing for 625-line standard-definition video. It is clocked by the 13.5 MHz pixel clock. From one pixel counter and one line counter it derives these outputs:

- active-low horizontal and vertical sync pulses;
- an active-video flag;
- a field flag;
- the coordinates of the current pixel inside the visible area.

A downstream pixel source reads the coordinates and supplies colour data while the active flag is high.

Two modes are available.

- **Interlaced mode.** The generator runs 625-line frames of two fields. The vertical sync of the second field is placed half a line later with respect to horizontal sync, so the fields interleave into 576 visible rows at 25 frames per second.
- **Progressive mode.** The generator repeats the first field type only. This gives 312 lines per field, 288 visible rows, 50 fields per second and the same line rate.

The mode input is sampled while reset is held and again at every frame boundary. A field is therefore never cut short. All timing figures are fields of one parameter structure, with the defaults given below.

Top module: `sd_sync_gen`

## Requirements
- R1: A line lasts `h_total` (864) clocks, and the pixel counter runs 0..863. `hsync_n_o` is low for exactly `hs_width` (64) clocks, at pixel counts 732..795, which is `hs_gap` (12) clocks after the last active pixel. It is never low while `active_o` is high.
- R2: In interlaced mode a frame is 625 lines. Field 1 starts at line 0, pixel 0. Its vertical sync goes low at line 0, pixel 0 and stays low for 2.5 lines (2160 clocks), returning high at line 2, pixel 432.
- R3: In interlaced mode, the field-2 vertical sync goes low at line 312, pixel 432 (mid-line) and stays low for 2.5 lines, returning high at line 315, pixel 0.
- R4: `field_o` is 0 during field 1 and 1 during field 2. It rises at line 312, pixel 432 and falls at the frame wrap.
- R5: In progressive mode every field is 312 lines. Vertical sync always starts at pixel 0 of line 0 and lasts 2.5 lines. `field_o` stays 0.
- R6: Each field has 288 active lines that start 23 lines after the field begins. These are lines 23..310 in field 1 and lines 335..622 in field 2. Within an active line, pixels 0..719 are active.
- R7: `pix_y_o` numbers the visible rows as follows. In progressive mode it is the row within the field (0..287). In interlaced mode it is 2×row for field 1 and 2×row+1 for field 2, so the two fields interleave over 0..575.
- R8: While `active_o` is high, `pix_x_o` equals the pixel count (0..719). While it is low, `pix_x_o` and `pix_y_o` are both 0.
- R9: A change of `interlace_i` takes effect only at the next frame wrap. The frame wrap is line 0, pixel 0 after the last line of the current mode.
- R10: While `rst_i` is high (synchronous), both counters are held at 0. The outputs then show line 0, pixel 0: `hsync_n_o` is 1, `vsync_n_o` is 0, and `active_o` and `field_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Pixel clock |
| rst_i | input | 1 | Synchronous reset, active high |
| interlace_i | input | 1 | 1 selects interlaced mode, 0 selects progressive mode |
| hsync_n_o | output | 1 | Horizontal sync, active low |
| vsync_n_o | output | 1 | Vertical sync, active low |
| active_o | output | 1 | High inside the visible area |
| field_o | output | 1 | 0 during field 1, 1 during field 2 |
| pix_x_o | output | XW (10) | Pixel within the active line, 0 when blanked |
| pix_y_o | output | YW (10) | Visible row number, 0 when blanked |

## Verification
The bench runs the generator with a scaled timing structure so that whole frames fit in a short run. The stimulus covers three patterns:

- **Interlaced throughout.** Sync, field and coordinate values are sampled at the edges of every region. This separates the field-1 vertical sync from the mid-line field-2 vertical sync, and the even rows from the odd rows.
- **Progressive throughout.** The same points are sampled. This shows that the line counter wraps after one field and that neither the half-line offset nor field 2 ever appears.
- **Mode flipped mid-frame, in each direction.** The bench confirms that the old mode holds until the frame wrap and that the new mode applies after it.

Pulse widths are measured by counting low clocks over whole fields and lines.

// File: rtl/sd_sync_pkg.sv
package sd_sync_pkg;

  typedef struct packed {
    int h_total;      // clocks per line (even)
    int h_active;     // visible pixels per line
    int hs_gap;       // clocks from end of active to hsync
    int hs_width;     // hsync low clocks
    int f_lines;      // whole lines per field
    int vs_full;      // whole lines of vsync before the half line
    int v_act_start;  // first active line within a field
    int v_active;     // active lines per field
  } timing_t;

  localparam timing_t TIM_625 = '{864, 720, 12, 64, 312, 2, 23, 288};

  function automatic int lin_pos(timing_t t, int v, int h);
    return v * t.h_total + h;
  endfunction

  function automatic int f2_start(timing_t t);
    return t.f_lines * t.h_total + t.h_total / 2;
  endfunction

  function automatic logic in_hsync(timing_t t, int h);
    return (h >= t.h_active + t.hs_gap) && (h < t.h_active + t.hs_gap + t.hs_width);
  endfunction

  function automatic logic in_field2(timing_t t, int v, int h, logic il);
    return il && (lin_pos(t, v, h) >= f2_start(t));
  endfunction

  function automatic logic in_vsync(timing_t t, int v, int h, logic il);
    int p;
    int len;
    p   = lin_pos(t, v, h);
    len = t.vs_full * t.h_total + t.h_total / 2;
    return (p < len) || (il && p >= f2_start(t) && p < f2_start(t) + len);
  endfunction

  // Row within the field, or -1 when the position is blanked.
  function automatic int act_row(timing_t t, int v, int h, logic il);
    int rel;
    rel = in_field2(t, v, h, il) ? v - (t.f_lines + t.v_act_start) : v - t.v_act_start;
    if (rel >= 0 && rel < t.v_active && h < t.h_active) return rel;
    return -1;
  endfunction

endpackage

// File: rtl/sd_sync_hcount.sv
module sd_sync_hcount #(
  parameter int H_TOTAL = 864,
  parameter int HW      = 10
) (
  input  logic          clk_i,
  input  logic          rst_i,
  output logic [HW-1:0] h_o,
  output logic          line_end_o
);
  assign line_end_o = (h_o == HW'(H_TOTAL - 1));

  always_ff @(posedge clk_i) begin
    if (rst_i)           h_o <= '0;
    else if (line_end_o) h_o <= '0;
    else                 h_o <= h_o + 1'b1;
  end
endmodule

// File: rtl/sd_sync_vcount.sv
module sd_sync_vcount #(
  parameter int F_LINES = 312,
  parameter int VW      = 10
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          il_i,
  input  logic          line_end_i,
  output logic [VW-1:0] v_o,
  output logic          il_o,
  output logic          frame_end_o
);
  logic [VW-1:0] last_line;

  // Interlaced: 2*F_LINES+1 lines per frame; progressive: F_LINES lines.
  assign last_line   = il_o ? VW'(2 * F_LINES) : VW'(F_LINES - 1);
  assign frame_end_o = line_end_i && (v_o == last_line);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      v_o  <= '0;
      il_o <= il_i;
    end else if (frame_end_o) begin
      v_o  <= '0;
      il_o <= il_i;
    end else if (line_end_i) begin
      v_o  <= v_o + 1'b1;
    end
  end
endmodule

// File: rtl/sd_sync_decode.sv
module sd_sync_decode
  import sd_sync_pkg::*;
#(
  parameter timing_t TIM = TIM_625,
  parameter int      HW  = 10,
  parameter int      VW  = 10,
  parameter int      XW  = 10,
  parameter int      YW  = 10
) (
  input  logic [HW-1:0] h_i,
  input  logic [VW-1:0] v_i,
  input  logic          il_i,
  output logic          hsync_n_o,
  output logic          vsync_n_o,
  output logic          active_o,
  output logic          field_o,
  output logic [XW-1:0] pix_x_o,
  output logic [YW-1:0] pix_y_o
);
  int h_int;
  int v_int;
  int row;

  always_comb begin
    h_int     = int'(h_i);
    v_int     = int'(v_i);
    row       = act_row(TIM, v_int, h_int, il_i);
    hsync_n_o = !in_hsync(TIM, h_int);
    vsync_n_o = !in_vsync(TIM, v_int, h_int, il_i);
    field_o   = in_field2(TIM, v_int, h_int, il_i);
    active_o  = (row >= 0);
    pix_x_o   = '0;
    pix_y_o   = '0;
    if (active_o) begin
      pix_x_o = XW'(h_int);
      pix_y_o = il_i ? YW'(2 * row + (field_o ? 1 : 0)) : YW'(row);
    end
  end
endmodule

// File: rtl/sd_sync_gen.sv
module sd_sync_gen
  import sd_sync_pkg::*;
#(
  parameter timing_t TIM = TIM_625,
  parameter int      XW  = 10,
  parameter int      YW  = 10
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          interlace_i,
  output logic          hsync_n_o,
  output logic          vsync_n_o,
  output logic          active_o,
  output logic          field_o,
  output logic [XW-1:0] pix_x_o,
  output logic [YW-1:0] pix_y_o
);
  localparam int HW = $clog2(TIM.h_total);
  localparam int VW = $clog2(2 * TIM.f_lines + 1);

  logic [HW-1:0] h_q;
  logic [VW-1:0] v_q;
  logic          il_q;
  logic          line_end;
  logic          frame_end;

  sd_sync_hcount #(.H_TOTAL(TIM.h_total), .HW(HW)) u_hcount (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .h_o        (h_q),
    .line_end_o (line_end)
  );

  sd_sync_vcount #(.F_LINES(TIM.f_lines), .VW(VW)) u_vcount (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .il_i        (interlace_i),
    .line_end_i  (line_end),
    .v_o         (v_q),
    .il_o        (il_q),
    .frame_end_o (frame_end)
  );

  sd_sync_decode #(.TIM(TIM), .HW(HW), .VW(VW), .XW(XW), .YW(YW)) u_decode (
    .h_i       (h_q),
    .v_i       (v_q),
    .il_i      (il_q),
    .hsync_n_o (hsync_n_o),
    .vsync_n_o (vsync_n_o),
    .active_o  (active_o),
    .field_o   (field_o),
    .pix_x_o   (pix_x_o),
    .pix_y_o   (pix_y_o)
  );
endmodule

// File: rtl/sd_sync_gen_chk.sv
module sd_sync_gen_chk
  import sd_sync_pkg::*;
#(
  parameter timing_t TIM = TIM_625,
  parameter int      HW  = 10,
  parameter int      VW  = 10,
  parameter int      XW  = 10,
  parameter int      YW  = 10
) (
  input logic          clk_i,
  input logic          rst_i,
  input logic          hsync_n_o,
  input logic          vsync_n_o,
  input logic          active_o,
  input logic          field_o,
  input logic [XW-1:0] pix_x_o,
  input logic [YW-1:0] pix_y_o,
  input logic [HW-1:0] h_q,
  input logic [VW-1:0] v_q,
  input logic          il_q,
  input logic          frame_end
);
  AST_HS_OUTSIDE_ACTIVE: assert property (@(posedge clk_i) disable iff (rst_i)
    !hsync_n_o |-> !active_o); // R1

  AST_F1_VS_LINE_START: assert property (@(posedge clk_i) disable iff (rst_i)
    ($fell(vsync_n_o) && !field_o) |-> (h_q == '0)); // R2

  AST_F2_VS_MID_LINE: assert property (@(posedge clk_i) disable iff (rst_i)
    ($fell(vsync_n_o) && field_o) |-> (h_q == HW'(TIM.h_total / 2))); // R3

  AST_FIELD_EDGE_POS: assert property (@(posedge clk_i) disable iff (rst_i)
    !$stable(field_o) |-> (h_q == '0 || h_q == HW'(TIM.h_total / 2))); // R4

  AST_PROG_FIELD_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
    !il_q |-> !field_o); // R5

  AST_BLANK_COORDS_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
    !active_o |-> (pix_x_o == '0 && pix_y_o == '0)); // R8

  AST_X_STEPS: assert property (@(posedge clk_i) disable iff (rst_i)
    (active_o && $past(active_o)) |-> (pix_x_o == $past(pix_x_o) + XW'(1))); // R8

  AST_MODE_AT_WRAP: assert property (@(posedge clk_i) disable iff (rst_i)
    !$stable(il_q) |-> $past(frame_end)); // R9

  AST_WRAP_TO_ORIGIN: assert property (@(posedge clk_i) disable iff (rst_i)
    frame_end |=> (h_q == '0 && v_q == '0)); // R9
endmodule

bind sd_sync_gen sd_sync_gen_chk #(.TIM(TIM), .HW(HW), .VW(VW), .XW(XW), .YW(YW)) u_chk (
  .clk_i     (clk_i),
  .rst_i     (rst_i),
  .hsync_n_o (hsync_n_o),
  .vsync_n_o (vsync_n_o),
  .active_o  (active_o),
  .field_o   (field_o),
  .pix_x_o   (pix_x_o),
  .pix_y_o   (pix_y_o),
  .h_q       (h_q),
  .v_q       (v_q),
  .il_q      (il_q),
  .frame_end (frame_end)
);

// File: tb/sd_sync_gen_bench.sv
module sd_sync_gen_bench;
  import sd_sync_pkg::*;

  // Scaled timing: 40-clock lines, 12-line fields, 25-line interlaced frames.
  localparam timing_t T = '{40, 24, 2, 6, 12, 2, 3, 8};

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       il  = 1'b1;
  logic       hs_n, vs_n, act, fld;
  logic [9:0] px, py;

  int checks   = 0;
  int failures = 0;
  int pos      = 0;

  always #2 clk = ~clk;

  sd_sync_gen #(.TIM(T), .XW(10), .YW(10)) u_sd_sync_gen (
    .clk_i(clk), .rst_i(rst), .interlace_i(il),
    .hsync_n_o(hs_n), .vsync_n_o(vs_n), .active_o(act), .field_o(fld),
    .pix_x_o(px), .pix_y_o(py)
  );

  typedef struct packed {
    logic il; int cyc; logic hs; logic vs; logic act; logic fld; int x; int y; int req;
  } vec_t;

  // cyc = line*40 + pixel after reset release
  localparam vec_t VECS [21] = '{
    '{1'b1,    0, 1'b1, 1'b0, 1'b0, 1'b0,  0,  0,  2}, // R2 frame origin
    '{1'b1,   99, 1'b1, 1'b0, 1'b0, 1'b0,  0,  0,  2}, // R2 last vsync clock
    '{1'b1,  100, 1'b1, 1'b1, 1'b0, 1'b0,  0,  0,  2}, // R2 vsync ends mid-line
    '{1'b1,  120, 1'b1, 1'b1, 1'b1, 1'b0,  0,  0,  6}, // R6 first active line
    '{1'b1,  183, 1'b1, 1'b1, 1'b1, 1'b0, 23,  2,  7}, // R7 even row
    '{1'b1,  184, 1'b1, 1'b1, 1'b0, 1'b0,  0,  0,  8}, // R8 blank after active
    '{1'b1,  186, 1'b0, 1'b1, 1'b0, 1'b0,  0,  0,  1}, // R1 hsync start
    '{1'b1,  191, 1'b0, 1'b1, 1'b0, 1'b0,  0,  0,  1}, // R1 hsync last
    '{1'b1,  192, 1'b1, 1'b1, 1'b0, 1'b0,  0,  0,  1}, // R1 hsync end
    '{1'b1,  499, 1'b1, 1'b1, 1'b0, 1'b0,  0,  0,  4}, // R4 before field 2
    '{1'b1,  500, 1'b1, 1'b0, 1'b0, 1'b1,  0,  0,  3}, // R3 mid-line vsync
    '{1'b1,  599, 1'b1, 1'b0, 1'b0, 1'b1,  0,  0,  3}, // R3 last vsync clock
    '{1'b1,  600, 1'b1, 1'b1, 1'b1, 1'b1,  0,  1,  6}, // R6 field 2 first row
    '{1'b1,  885, 1'b1, 1'b1, 1'b1, 1'b1,  5, 15,  7}, // R7 odd row
    '{1'b1,  999, 1'b1, 1'b1, 1'b0, 1'b1,  0,  0,  4}, // R4 end of frame
    '{1'b1, 1000, 1'b1, 1'b0, 1'b0, 1'b0,  0,  0,  2}, // R2 625-line wrap
    '{1'b0,  480, 1'b1, 1'b0, 1'b0, 1'b0,  0,  0,  5}, // R5 312-line wrap
    '{1'b0,  500, 1'b1, 1'b0, 1'b0, 1'b0,  0,  0,  5}, // R5 no half-line shift
    '{1'b0,  407, 1'b1, 1'b1, 1'b1, 1'b0,  7,  7,  7}, // R7 progressive row
    '{1'b0,  440, 1'b1, 1'b1, 1'b0, 1'b0,  0,  0,  6}, // R6 after last row
    '{1'b0,  100, 1'b1, 1'b1, 1'b0, 1'b0,  0,  0,  5}  // R5 vsync length
  };

  task automatic chk(input string req, input int act_v, input int exp_v);
    checks++;
    if (act_v != exp_v) begin
      failures++;
      $display("FAIL %s at cyc %0d: actual=%0d expected=%0d", req, pos, act_v, exp_v);
    end
  endtask

  task automatic do_reset(input logic mode);
    rst = 1'b1;
    il  = mode;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    pos = 0;
  endtask

  task automatic run_to(input int c);
    while (pos < c) begin
      @(posedge clk);
      pos++;
    end
    #1;
  endtask

  task automatic check_all(input string req, input vec_t e);
    chk(req, int'(hs_n), int'(e.hs));
    chk(req, int'(vs_n), int'(e.vs));
    chk(req, int'(act), int'(e.act));
    chk(req, int'(fld), int'(e.fld));
    chk(req, int'(px), e.x);
    chk(req, int'(py), e.y);
  endtask

  initial begin
    #(4 * 200000);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int cnt;
    // R10: outputs while reset is held
    rst = 1'b1;
    il  = 1'b1;
    @(posedge clk);
    @(posedge clk);
    #1;
    check_all("R10", '{1'b1, 0, 1'b1, 1'b0, 1'b0, 1'b0, 0, 0, 10});

    foreach (VECS[i]) begin
      do_reset(VECS[i].il);
      run_to(VECS[i].cyc);
      check_all($sformatf("R%0d", VECS[i].req), VECS[i]);
    end

    // R2 / R3: vsync low for 2.5 lines in each interlaced field
    do_reset(1'b1);
    cnt = 0;
    for (int c = 0; c < 500; c++) begin run_to(c); if (!vs_n) cnt++; end
    chk("R2", cnt, 100);
    cnt = 0;
    for (int c = 500; c < 1000; c++) begin run_to(c); if (!vs_n) cnt++; end
    chk("R3", cnt, 100);

    // R1 / R6: hsync and active widths over one active line
    do_reset(1'b0);
    cnt = 0;
    for (int c = 160; c < 200; c++) begin run_to(c); if (!hs_n) cnt++; end
    chk("R1", cnt, 6);
    do_reset(1'b0);
    cnt = 0;
    for (int c = 160; c < 200; c++) begin run_to(c); if (act) cnt++; end
    chk("R6", cnt, 24);

    // R9: interlaced -> progressive request mid-frame
    do_reset(1'b1);
    run_to(300);
    il = 1'b0;
    run_to(520);
    chk("R9", int'(fld), 1);
    run_to(1200);
    chk("R9", int'(py), 2);
    run_to(1500);
    chk("R9", int'(fld), 0);
    chk("R9", int'(vs_n), 0);

    // R9: progressive -> interlaced request mid-frame
    do_reset(1'b0);
    run_to(100);
    il = 1'b1;
    run_to(460);
    chk("R9", int'(vs_n), 1);
    run_to(980);
    chk("R9", int'(fld), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule